// File: doc/BRIEF.md
# Condition Code Flag Generator

This block produces the updated condition register of an 8/16-bit accumulator processor after an arithmetic or data-movement step. The datapath supplies the two operands, the result it computed, the bit pushed out by the shifter, the class of the operation, a width select and the current condition register. The block returns the new condition register in the same cycle. It contains no storage.

Carry and overflow are derived from bitwise terms on the sign columns of the operands and the result. No second adder is used, so the ALU's own result is the only sum in the design. Only the sign, zero, overflow and carry bits can change. Which of them change depends on the operation class. Every other bit of the register is returned as it came in.

Top module: `ccf_flag_unit`

## Requirements
- R1: For class ADD (op_cls = 2'b00), carry (bit 0) is the top bit, at the selected width, of (a&b)|(b&~r)|(a&~r). With a consistent result this equals the unsigned carry-out of a+b.
- R2: For class ADD, overflow (bit 1) is the top bit of (a&b&~r)|(~a&~b&r), i.e. signed overflow of a+b.
- R3: For class SUB (op_cls = 2'b01), carry is a borrow: the top bit of (~a&b)|(b&r)|(~a&r). It is 1 exactly when a < b unsigned.
- R4: For class SUB, overflow is the top bit of (a&~b&~r)|(~a&b&r), i.e. signed overflow of a−b.
- R5: For every class, the negative bit (bit 3) equals the result's sign bit: r[7] when wide = 0, r[15] when wide = 1.
- R6: For every class, the zero bit (bit 2) is 1 exactly when the result is zero at the selected width.
- R7: For class TEST (op_cls = 2'b10), overflow is cleared and carry keeps its incoming value.
- R8: For class SHIFT (op_cls = 2'b11), carry equals shift_cout, and overflow equals the new negative bit XOR the new carry.
- R9: Bits 7..4 of the register (S, X, H, I) pass from flags_in to flags_out unchanged for every class and width.
- R10: With wide = 0, bits 15..8 of the operands and of the result have no effect on flags_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 16 | First operand (low byte used when wide = 0) |
| opd_b | input | 16 | Second operand |
| res | input | 16 | Result produced by the ALU |
| shift_cout | input | 1 | Bit shifted out by the shifter |
| op_cls | input | 2 | 00 add, 01 subtract, 10 test/load, 11 shift |
| wide | input | 1 | 0 byte width, 1 word width |
| flags_in | input | 8 | Current condition register, S X H I N Z V C from bit 7 to bit 0 |
| flags_out | output | 8 | Updated condition register |

## Verification
Addition and subtraction are driven across the signed and unsigned wrap points, 0x7F+1, 0x80−1, 0xFF+1 and 0xFFFF+1. These cases separate carry from overflow and borrow from overflow at each width. Test and shift patterns run with the incoming carry at both values, which shows whether C is held, replaced or folded into V. Byte operations are repeated with random upper halves, and the condition register is loaded with patterns in its upper nibble, to show that no bit outside the selected width or the affected set leaks through. A seeded random sweep of all classes and widths is compared against an integer reference model.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

   typedef enum logic [1:0] {
      CCF_ADD   = 2'b00,
      CCF_SUB   = 2'b01,
      CCF_TEST  = 2'b10,
      CCF_SHIFT = 2'b11
   } ccf_op_e;

   // Per-width sign-column terms produced by one lane
   typedef struct packed {
      logic add_c;
      logic add_v;
      logic sub_c;
      logic sub_v;
      logic neg;
      logic zero;
   } ccf_lane_t;

   // New values for the four arithmetic flags
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccf_nzvc_t;

endpackage

// File: rtl/ccf_lane.sv
module ccf_lane
   import ccf_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] r,
   output ccf_lane_t    terms
);

   localparam int unsigned MSB = W - 1;

   if (W < 2) begin : g_bad_w
      $error("ccf_lane: W must be at least 2");
   end

   logic [W-1:0] add_cv, add_ov, sub_cv, sub_ov;

   always_comb begin
      add_cv = (a & b) | (b & ~r) | (a & ~r);
      add_ov = (a & b & ~r) | (~a & ~b & r);
      sub_cv = (~a & b) | (b & r) | (~a & r);
      sub_ov = (a & ~b & ~r) | (~a & b & r);
   end

   always_comb begin
      terms.add_c = add_cv[MSB];
      terms.add_v = add_ov[MSB];
      terms.sub_c = sub_cv[MSB];
      terms.sub_v = sub_ov[MSB];
      terms.neg   = r[MSB];
      terms.zero  = ~|r;
   end

endmodule

// File: rtl/ccf_rules.sv
module ccf_rules
   import ccf_pkg::*;
(
   input  ccf_lane_t byte_terms,
   input  ccf_lane_t word_terms,
   input  logic      wide,
   input  ccf_op_e   op,
   input  logic      shift_cout,
   output ccf_nzvc_t nzvc,
   output ccf_nzvc_t upd
);

   ccf_lane_t sel;

   always_comb begin
      sel = wide ? word_terms : byte_terms;
   end

   always_comb begin
      nzvc.n = sel.neg;
      nzvc.z = sel.zero;
      nzvc.v = 1'b0;
      nzvc.c = 1'b0;
      upd    = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
      unique case (op)
         CCF_ADD: begin
            nzvc.c = sel.add_c;
            nzvc.v = sel.add_v;
         end
         CCF_SUB: begin
            nzvc.c = sel.sub_c;
            nzvc.v = sel.sub_v;
         end
         CCF_TEST: begin
            nzvc.v = 1'b0;
            upd.c  = 1'b0;
         end
         CCF_SHIFT: begin
            nzvc.c = shift_cout;
            nzvc.v = sel.neg ^ shift_cout;
         end
         default: begin
            upd = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};
         end
      endcase
   end

endmodule

// File: rtl/ccf_merge.sv
module ccf_merge
   import ccf_pkg::*;
#(
   parameter int unsigned FLAG_W = 8,
   parameter int unsigned POS_C  = 0,
   parameter int unsigned POS_V  = 1,
   parameter int unsigned POS_Z  = 2,
   parameter int unsigned POS_N  = 3
) (
   input  logic [FLAG_W-1:0] flags_in,
   input  ccf_nzvc_t         nzvc,
   input  ccf_nzvc_t         upd,
   output logic [FLAG_W-1:0] flags_out
);

   if (POS_C >= FLAG_W || POS_V >= FLAG_W || POS_Z >= FLAG_W || POS_N >= FLAG_W) begin : g_bad_pos
      $error("ccf_merge: flag position outside register");
   end
   if (POS_C == POS_V || POS_C == POS_Z || POS_C == POS_N ||
       POS_V == POS_Z || POS_V == POS_N || POS_Z == POS_N) begin : g_dup_pos
      $error("ccf_merge: flag positions must be distinct");
   end

   logic [FLAG_W-1:0] new_vec;
   logic [FLAG_W-1:0] upd_vec;

   always_comb begin
      new_vec        = '0;
      upd_vec        = '0;
      new_vec[POS_C] = nzvc.c;
      new_vec[POS_V] = nzvc.v;
      new_vec[POS_Z] = nzvc.z;
      new_vec[POS_N] = nzvc.n;
      upd_vec[POS_C] = upd.c;
      upd_vec[POS_V] = upd.v;
      upd_vec[POS_Z] = upd.z;
      upd_vec[POS_N] = upd.n;
   end

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      assign flags_out[i] = upd_vec[i] ? new_vec[i] : flags_in[i];
   end

endmodule

// File: rtl/ccf_flag_unit.sv
module ccf_flag_unit
   import ccf_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned FLAG_W = 8,
   parameter int unsigned POS_C  = 0,
   parameter int unsigned POS_V  = 1,
   parameter int unsigned POS_Z  = 2,
   parameter int unsigned POS_N  = 3
) (
   input  logic [WORD_W-1:0] opd_a,
   input  logic [WORD_W-1:0] opd_b,
   input  logic [WORD_W-1:0] res,
   input  logic              shift_cout,
   input  logic [1:0]        op_cls,
   input  logic              wide,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out
);

   localparam int unsigned BMSB = BYTE_W - 1;

   if (BYTE_W >= WORD_W) begin : g_bad_width
      $error("ccf_flag_unit: BYTE_W must be narrower than WORD_W");
   end
   if (FLAG_W < 4) begin : g_bad_flags
      $error("ccf_flag_unit: FLAG_W must hold four flags");
   end

   ccf_lane_t byte_terms, word_terms;
   ccf_nzvc_t nzvc, upd;
   ccf_op_e   op;

   always_comb op = ccf_op_e'(op_cls);

   ccf_lane #(.W(BYTE_W)) u_lane_byte (
      .a     (opd_a[BMSB:0]),
      .b     (opd_b[BMSB:0]),
      .r     (res[BMSB:0]),
      .terms (byte_terms)
   );

   ccf_lane #(.W(WORD_W)) u_lane_word (
      .a     (opd_a),
      .b     (opd_b),
      .r     (res),
      .terms (word_terms)
   );

   ccf_rules u_rules (
      .byte_terms (byte_terms),
      .word_terms (word_terms),
      .wide       (wide),
      .op         (op),
      .shift_cout (shift_cout),
      .nzvc       (nzvc),
      .upd        (upd)
   );

   ccf_merge #(
      .FLAG_W (FLAG_W),
      .POS_C  (POS_C),
      .POS_V  (POS_V),
      .POS_Z  (POS_Z),
      .POS_N  (POS_N)
   ) u_merge (
      .flags_in  (flags_in),
      .nzvc      (nzvc),
      .upd       (upd),
      .flags_out (flags_out)
   );

endmodule

// File: rtl/ccf_flag_chk.sv
module ccf_flag_chk #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned FLAG_W = 8,
   parameter int unsigned POS_C  = 0,
   parameter int unsigned POS_V  = 1,
   parameter int unsigned POS_Z  = 2,
   parameter int unsigned POS_N  = 3
) (
   input logic [WORD_W-1:0] res,
   input logic              shift_cout,
   input logic [1:0]        op_cls,
   input logic              wide,
   input logic [FLAG_W-1:0] flags_in,
   input logic [FLAG_W-1:0] flags_out
);

   logic [FLAG_W-1:0] keep;
   logic              sign_w, zero_w;

   always_comb begin
      keep        = '1;
      keep[POS_C] = 1'b0;
      keep[POS_V] = 1'b0;
      keep[POS_Z] = 1'b0;
      keep[POS_N] = 1'b0;
      sign_w = wide ? res[WORD_W-1] : res[BYTE_W-1];
      zero_w = wide ? (res == '0) : (res[BYTE_W-1:0] == '0);
   end

   always_comb begin
      assert_keep_bits_R9: assert ((flags_out & keep) == (flags_in & keep))
         else $error("untouched flag bits changed");
      assert_sign_copy_R5: assert (flags_out[POS_N] == sign_w)
         else $error("N differs from result sign");
      assert_zero_detect_R6: assert (flags_out[POS_Z] == zero_w)
         else $error("Z differs from zero test");
      if (op_cls == 2'b10) begin
         assert_test_v_clear_R7: assert (flags_out[POS_V] == 1'b0)
            else $error("test class left V set");
         assert_test_c_hold_R7: assert (flags_out[POS_C] == flags_in[POS_C])
            else $error("test class changed C");
      end
      if (op_cls == 2'b11) begin
         assert_shift_c_R8: assert (flags_out[POS_C] == shift_cout)
            else $error("shift C not the shifted-out bit");
         assert_shift_v_R8: assert (flags_out[POS_V] == (flags_out[POS_N] ^ flags_out[POS_C]))
            else $error("shift V not N xor C");
      end
   end

endmodule

bind ccf_flag_unit ccf_flag_chk #(
   .WORD_W (WORD_W),
   .BYTE_W (BYTE_W),
   .FLAG_W (FLAG_W),
   .POS_C  (POS_C),
   .POS_V  (POS_V),
   .POS_Z  (POS_Z),
   .POS_N  (POS_N)
) u_chk (
   .res        (res),
   .shift_cout (shift_cout),
   .op_cls     (op_cls),
   .wide       (wide),
   .flags_in   (flags_in),
   .flags_out  (flags_out)
);

// File: tb/ccf_flag_unit_bench.sv
module ccf_flag_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic [15:0] opd_a = '0, opd_b = '0, res = '0;
   logic        shift_cout = 1'b0;
   logic [1:0]  op_cls = 2'b00;
   logic        wide = 1'b0;
   logic [7:0]  flags_in = '0;
   logic [7:0]  flags_out;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   ccf_flag_unit u_ccf_flag_unit (
      .opd_a      (opd_a),
      .opd_b      (opd_b),
      .res        (res),
      .shift_cout (shift_cout),
      .op_cls     (op_cls),
      .wide       (wide),
      .flags_in   (flags_in),
      .flags_out  (flags_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // Integer reference model: NZVC = bits 3..0, upper nibble held
   function automatic logic [7:0] ref_flags(input logic [15:0] a, b, r,
                                            input logic co, input logic [1:0] op,
                                            input logic wd, input logic [7:0] fin);
      int w  = wd ? 16 : 8;
      int m  = wd ? 32'hFFFF : 32'hFF;
      int am = int'(a) & m;
      int bm = int'(b) & m;
      int rm = int'(r) & m;
      int sb = 1 << (w - 1);
      logic n = (rm & sb) != 0;
      logic z = (rm == 0);
      logic v = 1'b0;
      logic c = fin[0];
      logic [7:0] f = fin;
      case (op)
         2'b00: begin
            c = (((am + bm) >> w) & 1) != 0;
            v = ((am & sb) == (bm & sb)) && ((rm & sb) != (am & sb));
         end
         2'b01: begin
            c = am < bm;
            v = ((am & sb) != (bm & sb)) && ((rm & sb) != (am & sb));
         end
         2'b10: begin
            v = 1'b0;
            c = fin[0];
         end
         default: begin
            c = co;
            v = n ^ co;
         end
      endcase
      f[3] = n; f[2] = z; f[1] = v; f[0] = c;
      return f;
   endfunction

   task automatic apply_check(input logic [15:0] a, b, r, input logic co,
                              input logic [1:0] op, input logic wd,
                              input logic [7:0] fin, input string tag);
      logic [7:0] exp;
      opd_a = a; opd_b = b; res = r; shift_cout = co;
      op_cls = op; wide = wd; flags_in = fin;
      #(CLK_PERIOD/4);
      exp = ref_flags(a, b, r, co, op, wd, fin);
      n_checks++;
      if (flags_out !== exp) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h r=%h op=%0d wide=%0b got %h expected %h",
                  tag, a, b, r, op, wd, flags_out, exp);
      end
      #(CLK_PERIOD/4);
   endtask

   task automatic do_add(input logic [15:0] a, b, input logic wd,
                         input logic [7:0] fin, input string tag);
      apply_check(a, b, a + b, 1'b0, 2'b00, wd, fin, tag);
   endtask

   task automatic do_sub(input logic [15:0] a, b, input logic wd,
                         input logic [7:0] fin, input string tag);
      apply_check(a, b, a - b, 1'b0, 2'b01, wd, fin, tag);
   endtask

   task automatic t_idle_state;
      // all-zero inputs: add 0+0 gives only Z
      apply_check('0, '0, '0, 1'b0, 2'b00, 1'b0, 8'h00, "R6 idle zero add");
      n_checks++;
      if (flags_out !== 8'h04) begin
         n_fail++;
         $display("FAIL R6 idle: got %h expected 04", flags_out);
      end
   endtask

   task automatic t_add_corners;
      do_add(16'h007F, 16'h0001, 1'b0, 8'h00, "R2 byte 7F+1");
      do_add(16'h00FF, 16'h0001, 1'b0, 8'h00, "R1 byte FF+1");
      do_add(16'h0080, 16'h0080, 1'b0, 8'h00, "R1 R2 byte 80+80");
      do_add(16'h7FFF, 16'h0001, 1'b1, 8'h00, "R2 word 7FFF+1");
      do_add(16'hFFFF, 16'h0001, 1'b1, 8'h00, "R1 word FFFF+1");
      do_add(16'h1234, 16'h4321, 1'b1, 8'h0F, "R1 word plain");
   endtask

   task automatic t_sub_corners;
      do_sub(16'h0080, 16'h0001, 1'b0, 8'h00, "R4 byte 80-1");
      do_sub(16'h0000, 16'h0001, 1'b0, 8'h00, "R3 byte 0-1 borrow");
      do_sub(16'h0005, 16'h0005, 1'b0, 8'h0F, "R3 R6 byte equal");
      do_sub(16'h8000, 16'h0001, 1'b1, 8'h00, "R4 word 8000-1");
      do_sub(16'h0001, 16'h8000, 1'b1, 8'h00, "R3 R4 word 1-8000");
   endtask

   task automatic t_test_class;
      apply_check(16'h0, 16'h0, 16'h0080, 1'b0, 2'b10, 1'b0, 8'h03, "R7 test C held 1");
      apply_check(16'h0, 16'h0, 16'h0000, 1'b1, 2'b10, 1'b1, 8'h02, "R7 test C held 0");
      apply_check(16'h0, 16'h0, 16'h8000, 1'b0, 2'b10, 1'b1, 8'h01, "R5 test word sign");
   endtask

   task automatic t_shift_class;
      apply_check(16'h0, 16'h0, 16'h0080, 1'b0, 2'b11, 1'b0, 8'h01, "R8 shift N1 C0");
      apply_check(16'h0, 16'h0, 16'h0080, 1'b1, 2'b11, 1'b0, 8'h00, "R8 shift N1 C1");
      apply_check(16'h0, 16'h0, 16'h0000, 1'b1, 2'b11, 1'b1, 8'h00, "R8 shift Z C1");
      apply_check(16'h0, 16'h0, 16'h4000, 1'b0, 2'b11, 1'b1, 8'h0F, "R8 shift word clear");
   endtask

   task automatic t_upper_nibble;
      for (int op = 0; op < 4; op++) begin
         apply_check(16'h0040, 16'h0041, 16'h0081, 1'b1, 2'(op), 1'b0, 8'hA5, "R9 nibble A");
         apply_check(16'h4000, 16'hC000, 16'h0000, 1'b0, 2'(op), 1'b1, 8'h5A, "R9 nibble 5");
      end
   endtask

   task automatic t_byte_upper_ignored;
      apply_check(16'hAB7F, 16'hCD01, 16'hEF80, 1'b0, 2'b00, 1'b0, 8'h00, "R10 add upper junk");
      apply_check(16'hFF00, 16'h0100, 16'h5500, 1'b0, 2'b01, 1'b0, 8'h00, "R10 sub zero low");
      apply_check(16'h0000, 16'h0000, 16'h8000, 1'b1, 2'b11, 1'b0, 8'h00, "R10 shift upper sign");
   endtask

   task automatic t_random_sweep;
      void'($urandom(32'h5EED));
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a = 16'($urandom);
         logic [15:0] b = 16'($urandom);
         logic [1:0]  op = 2'($urandom);
         logic        wd = 1'($urandom);
         logic [7:0]  fin = 8'($urandom);
         logic        co = 1'($urandom);
         logic [15:0] r = (op == 2'b00) ? a + b : (op == 2'b01) ? a - b : 16'($urandom);
         apply_check(a, b, r, co, op, wd, fin, "R1 R3 R5 R6 random");
      end
   endtask

   initial begin
      #(CLK_PERIOD/2);
      t_idle_state();
      t_add_corners();
      t_sub_corners();
      t_test_class();
      t_shift_class();
      t_upper_nibble();
      t_byte_upper_ignored();
      t_random_sweep();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule